// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers level-sensitive request lines from several devices, one non-maskable line and a small set of software-raised sources. It picks one winner by fixed priority, presents it to the CPU and runs the acknowledge handshake. It then reports a vector address and records the taken source so that only a more urgent source can interrupt the running handler. A return strobe from the CPU retires the innermost handler and restores the previous priority level.

Each source has a fixed index, and a lower index means higher priority:

| Index | Source |
|---|---|
| 0 | non-maskable line |
| 1 to NUM_IRQ | device lines `irq_lines[0]` upward |
| the last NUM_SW | software sources |

The vector address is a table base plus four times the index. The base comes from one of two fixed regions, chosen by `ext_table`. When a device is acknowledged it must confirm within a bounded number of cycles. If it does not, the controller reports a bus error instead of a vector.

Top module: `pvic_top`

## Requirements
- R1: A device or non-maskable line held high before clock edge E1 raises `int_req` after edge E3: two synchronizer stages, then one recognition stage.
- R2: Among simultaneous eligible sources the lowest index wins. The non-maskable line (index 0) beats every device, and `irq_lines[k]` (index k+1) beats `irq_lines[k+1]`.
- R3: The current level is the lowest set index in `nest_reg`, or idle when it is empty. Only a source whose index is below that level is requested. A more urgent source preempts and adds a second nest bit.
- R4: When `int_en` is 0, device and software sources raise no request. The non-maskable line is still requested and taken.
- R5: Taking a device source works as follows. `cpu_ack` while `int_req` is high drives `dev_ack` one-hot on bit k for `irq_lines[k]`. The controller waits there for `dev_vld`. The non-maskable and software sources skip this wait.
- R6: If `dev_vld` does not arrive within TIMEOUT (default 8) cycles of `dev_ack` rising, the controller does the following:
  - it drops `dev_ack`;
  - it pulses `bus_err` for one cycle;
  - it sets no bit in `latch_reg` or `nest_reg`.
- R7: A take pulses `vec_valid` for one cycle with `vec_addr` = base + 4 × index. The base is INT_BASE (0x20000) when `ext_table` is 0, and EXT_BASE (0x40000) when it is 1. On the next cycle bit `index` is set in both `latch_reg` and `nest_reg`.
- R8: A one-cycle `rti` clears the lowest set bit of `nest_reg` and the same bit of `latch_reg`.
- R9: A pulse on `sw_raise[j]` sets `latch_reg` bit NUM_IRQ+1+j, which is a pending software request. That request is taken like the others, and the lowest software index goes first.
- R10: While `rst_n` is low, all of the following are 0: `int_req`, `dev_ack`, `vec_valid`, `bus_err`, `latch_reg` and `nest_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_IRQ | Level-sensitive device requests |
| nmi | input | 1 | Non-maskable request, level-sensitive |
| sw_raise | input | NUM_SW | One-cycle strobes that raise software sources |
| int_en | input | 1 | Global enable for device and software sources |
| ext_table | input | 1 | Selects the external vector table base |
| cpu_ack | input | 1 | CPU accepts the presented request |
| dev_vld | input | 1 | Acknowledged device confirms its vector |
| rti | input | 1 | Return from the innermost handler |
| int_req | output | 1 | Request presented to the CPU |
| dev_ack | output | NUM_IRQ | One-hot acknowledge to the selected device |
| vec_valid | output | 1 | One-cycle strobe, `vec_addr` valid |
| vec_addr | output | AW | Handler vector address |
| bus_err | output | 1 | One-cycle vector timeout pulse |
| latch_reg | output | NUM_IRQ+NUM_SW+1 | Taken and pending-software bits |
| nest_reg | output | NUM_IRQ+NUM_SW+1 | Active nesting bits |

## Verification
The bench targets the boundaries of priority and nesting:

- A request at or below the current level held high for many cycles must stay silent. A design that compared with "not lower" instead of "strictly higher" would re-enter the running handler.
- The non-maskable line is driven with `int_en` low. Simultaneous device and software requests must come out lowest index first. A reversed encoder would hand out the wrong vector address.
- The timeout is checked to the exact cycle, and no nest bit may be left behind. A design that latched before confirmation would block its own source for good.
- `rti` is checked to peel off only the innermost level. Clearing the wrong bit would unmask the outer handler's own source.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_WAITV = 2'd2,
        ST_TAKE  = 2'd3
    } pvic_state_e;
endpackage

// File: rtl/pvic_sync.sv
module pvic_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/pvic_prio.sv
module pvic_prio #(
    parameter int N  = 11,
    parameter int IW = 4
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          found
);
    // lowest set index wins
    always_comb begin
        idx   = IW'(N);
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pvic_top.sv
module pvic_top
    import pvic_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int NUM_SW  = 2,
    parameter int AW      = 32,
    parameter logic [AW-1:0] INT_BASE = 32'h0002_0000,
    parameter logic [AW-1:0] EXT_BASE = 32'h0004_0000,
    parameter int TIMEOUT = 8,
    localparam int NSRC  = 1 + NUM_IRQ + NUM_SW,
    localparam int IW    = $clog2(NSRC + 1),
    localparam int TW    = $clog2(TIMEOUT + 1),
    localparam int SW_LO = 1 + NUM_IRQ
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_lines,
    input  logic               nmi,
    input  logic [NUM_SW-1:0]  sw_raise,
    input  logic               int_en,
    input  logic               ext_table,
    input  logic               cpu_ack,
    input  logic               dev_vld,
    input  logic               rti,
    output logic               int_req,
    output logic [NUM_IRQ-1:0] dev_ack,
    output logic               vec_valid,
    output logic [AW-1:0]      vec_addr,
    output logic               bus_err,
    output logic [NSRC-1:0]    latch_reg,
    output logic [NSRC-1:0]    nest_reg
);
    typedef struct packed {
        pvic_state_e     st;
        logic [IW-1:0]   sel;
        logic [TW-1:0]   tmr;
        logic            be;
        logic [NSRC-1:0] lat;
        logic [NSRC-1:0] nest;
    } regs_t;

    regs_t r_d, r_q;

    // stage 1: synchronize level requests
    logic [NUM_IRQ:0] sync_q;
    pvic_sync #(.W(NUM_IRQ + 1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({irq_lines, nmi}),
        .q    (sync_q)
    );

    // current level from the nesting record
    logic [IW-1:0] top_idx;
    logic          nest_any;
    logic [IW-1:0] cur_lvl;
    pvic_prio #(.N(NSRC), .IW(IW)) u_cur (
        .vec  (r_q.nest),
        .idx  (top_idx),
        .found(nest_any)
    );
    assign cur_lvl = nest_any ? top_idx : IW'(NSRC);

    // pending sources and the level filter
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] above;
    always_comb begin
        pend                  = '0;
        pend[0]               = sync_q[0];
        pend[NUM_IRQ:1]       = sync_q[NUM_IRQ:1] & {NUM_IRQ{int_en}};
        pend[NSRC-1:SW_LO]    = r_q.lat[NSRC-1:SW_LO] & ~r_q.nest[NSRC-1:SW_LO]
                                & {NUM_SW{int_en}};
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_above
        assign above[g] = (IW'(g) < cur_lvl);
    end

    // stage 2: recognition
    logic [IW-1:0] win_idx;
    logic          win_any;
    pvic_prio #(.N(NSRC), .IW(IW)) u_win (
        .vec  (pend & above),
        .idx  (win_idx),
        .found(win_any)
    );

    logic sel_is_dev;
    assign sel_is_dev = (r_q.sel >= IW'(1)) && (r_q.sel <= IW'(NUM_IRQ));

    always_comb begin
        r_d    = r_q;
        r_d.be = 1'b0;
        for (int j = 0; j < NUM_SW; j++) begin
            if (sw_raise[j]) r_d.lat[SW_LO + j] = 1'b1;
        end
        if (rti && nest_any) begin
            r_d.nest[top_idx] = 1'b0;
            r_d.lat[top_idx]  = 1'b0;
        end
        case (r_q.st)
            ST_IDLE: begin
                if (win_any) begin
                    r_d.sel = win_idx;
                    r_d.st  = ST_REQ;
                end
            end
            ST_REQ: begin
                if (cpu_ack) begin
                    if (sel_is_dev) begin
                        r_d.st  = ST_WAITV;
                        r_d.tmr = '0;
                    end else begin
                        r_d.st = ST_TAKE;
                    end
                end
            end
            ST_WAITV: begin
                if (dev_vld) begin
                    r_d.st = ST_TAKE;
                end else if (r_q.tmr == TW'(TIMEOUT - 1)) begin
                    r_d.be  = 1'b1;
                    r_d.st  = ST_IDLE;
                    r_d.tmr = '0;
                end else begin
                    r_d.tmr = r_q.tmr + TW'(1);
                end
            end
            ST_TAKE: begin
                r_d.lat[r_q.sel]  = 1'b1;
                r_d.nest[r_q.sel] = 1'b1;
                r_d.st            = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, sel: '0, tmr: '0, be: 1'b0, lat: '0, nest: '0};
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_ack
        assign dev_ack[g] = (r_q.st == ST_WAITV) && (r_q.sel == IW'(g + 1));
    end

    assign int_req   = (r_q.st == ST_REQ);
    assign vec_valid = (r_q.st == ST_TAKE);
    assign vec_addr  = (ext_table ? EXT_BASE : INT_BASE) + (AW'(r_q.sel) << 2);
    assign bus_err   = r_q.be;
    assign latch_reg = r_q.lat;
    assign nest_reg  = r_q.nest;
endmodule

// File: rtl/pvic_chk.sv
module pvic_chk #(
    parameter int NUM_IRQ = 8,
    parameter int NSRC    = 11,
    parameter int AW      = 32,
    parameter logic [AW-1:0] INT_BASE = 32'h0002_0000,
    parameter logic [AW-1:0] EXT_BASE = 32'h0004_0000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ext_table,
    input logic               cpu_ack,
    input logic               dev_vld,
    input logic               rti,
    input logic               int_req,
    input logic [NUM_IRQ-1:0] dev_ack,
    input logic               vec_valid,
    input logic [AW-1:0]      vec_addr,
    input logic               bus_err,
    input logic [NSRC-1:0]    nest_reg
);
    logic [AW-1:0] base;
    assign base = ext_table ? EXT_BASE : INT_BASE;

    a_r5_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_ack));

    a_r5_vec_after_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ($past(int_req && cpu_ack) || $past(dev_vld && (dev_ack != '0))));

    a_r6_err_not_with_vec: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_err && vec_valid));

    a_r7_vec_in_table: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ((vec_addr[1:0] == 2'b00) && ((vec_addr - base) < AW'(4 * NSRC))));

    a_r7_nest_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !rti) |=> ($countones(nest_reg) == $countones($past(nest_reg)) + 1));

    a_r8_nest_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (rti && !vec_valid && (nest_reg != '0))
            |=> ($countones(nest_reg) == $countones($past(nest_reg)) - 1));
endmodule

bind pvic_top pvic_chk #(
    .NUM_IRQ (NUM_IRQ),
    .NSRC    (NSRC),
    .AW      (AW),
    .INT_BASE(INT_BASE),
    .EXT_BASE(EXT_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_table(ext_table),
    .cpu_ack  (cpu_ack),
    .dev_vld  (dev_vld),
    .rti      (rti),
    .int_req  (int_req),
    .dev_ack  (dev_ack),
    .vec_valid(vec_valid),
    .vec_addr (vec_addr),
    .bus_err  (bus_err),
    .nest_reg (nest_reg)
);

// File: tb/tb_pvic_top.sv
module tb_pvic_top;
    localparam int NI   = 8;
    localparam int NS   = 2;
    localparam int NSRC = 1 + NI + NS;
    localparam int TO   = 8;
    localparam logic [31:0] INTB = 32'h0002_0000;
    localparam logic [31:0] EXTB = 32'h0004_0000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n, nmi, int_en, ext_table, cpu_ack, dev_vld, rti;
    logic [NI-1:0]   irq_lines;
    logic [NS-1:0]   sw_raise;
    logic            int_req, vec_valid, bus_err;
    logic [NI-1:0]   dev_ack;
    logic [31:0]     vec_addr;
    logic [NSRC-1:0] latch_reg, nest_reg;

    pvic_top dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .nmi(nmi),
        .sw_raise(sw_raise), .int_en(int_en), .ext_table(ext_table),
        .cpu_ack(cpu_ack), .dev_vld(dev_vld), .rti(rti),
        .int_req(int_req), .dev_ack(dev_ack), .vec_valid(vec_valid),
        .vec_addr(vec_addr), .bus_err(bus_err),
        .latch_reg(latch_reg), .nest_reg(nest_reg)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(int idx, bit ext);
        return (ext ? EXTB : INTB) + 32'(4 * idx);
    endfunction

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic do_rti();
        rti = 1'b1;
        nxt();
        rti = 1'b0;
    endtask

    task automatic wait_req(string req);
        int n = 0;
        while (!int_req && n < 8) begin
            nxt();
            n++;
        end
        chk_eq(req, "int_req", int_req, 1);
    endtask

    // called at a negedge with int_req high
    task automatic service(int idx, bit vld, bit ext, string req);
        ext_table = ext;
        cpu_ack   = 1'b1;
        nxt();
        cpu_ack   = 1'b0;
        if (idx >= 1 && idx <= NI) begin
            chk_eq("R5", "dev_ack", dev_ack, 64'(1) << (idx - 1));
            if (vld) begin
                dev_vld = 1'b1;
                nxt();
                dev_vld = 1'b0;
            end else begin
                bit held = 1'b1;
                irq_lines = '0;
                for (int k = 0; k < TO - 1; k++) begin
                    nxt();
                    if (bus_err || dev_ack == '0) held = 1'b0;
                end
                chk_eq("R6", "ack held until timeout", held, 1);
                nxt();
                chk_eq("R6", "bus_err pulse", bus_err, 1);
                chk_eq("R6", "dev_ack dropped", dev_ack, 0);
                chk_eq("R6", "no vec on timeout", vec_valid, 0);
                nxt();
                chk_eq("R6", "bus_err one cycle", bus_err, 0);
                return;
            end
        end
        chk_eq("R7", "vec_valid", vec_valid, 1);
        chk_eq(req, "vec_addr", vec_addr, exp_addr(idx, ext));
        nxt();
        chk_eq("R7", "vec_valid one cycle", vec_valid, 0);
        chk_eq("R7", "nest bit", nest_reg[idx], 1);
        chk_eq("R7", "latch bit", latch_reg[idx], 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; nmi = 1'b0; int_en = 1'b0; ext_table = 1'b0;
        cpu_ack = 1'b0; dev_vld = 1'b0; rti = 1'b0;
        irq_lines = '0; sw_raise = '0;
        repeat (3) nxt();
        irq_lines = 8'hFF;
        nmi = 1'b1;
        repeat (4) nxt();
        // R10 reset state, with every line high
        chk_eq("R10", "int_req", int_req, 0);
        chk_eq("R10", "dev_ack", dev_ack, 0);
        chk_eq("R10", "vec_valid", vec_valid, 0);
        chk_eq("R10", "bus_err", bus_err, 0);
        chk_eq("R10", "latch_reg", latch_reg, 0);
        chk_eq("R10", "nest_reg", nest_reg, 0);
        irq_lines = '0;
        nmi = 1'b0;
        repeat (3) nxt();
        rst_n = 1'b1;
        int_en = 1'b1;
        repeat (3) nxt();

        // R1 latency: request before E1, int_req after E3
        irq_lines[3] = 1'b1;
        nxt();
        chk_eq("R1", "int_req after E1", int_req, 0);
        nxt();
        chk_eq("R1", "int_req after E2", int_req, 0);
        nxt();
        chk_eq("R1", "int_req after E3", int_req, 1);
        service(4, 1, 0, "R7");
        chk_eq("R7", "nest after take", nest_reg, 64'h10);

        // R3 same or lower level stays masked
        irq_lines[6] = 1'b1;
        repeat (6) nxt();
        chk_eq("R3", "masked int_req", int_req, 0);
        // R3 higher preempts
        irq_lines[1] = 1'b1;
        wait_req("R3");
        service(2, 1, 1, "R3");
        chk_eq("R3", "two nest levels", nest_reg, 64'h14);
        irq_lines[1] = 1'b0;
        repeat (2) nxt();
        do_rti();
        chk_eq("R8", "nest after inner rti", nest_reg, 64'h10);
        chk_eq("R8", "latch after inner rti", latch_reg, 64'h10);
        repeat (4) nxt();
        chk_eq("R3", "still masked after rti", int_req, 0);
        irq_lines = '0;
        repeat (2) nxt();
        do_rti();
        chk_eq("R8", "nest empty", nest_reg, 0);
        chk_eq("R8", "latch empty", latch_reg, 0);
        repeat (3) nxt();

        // R2 simultaneous devices
        irq_lines[5] = 1'b1;
        irq_lines[2] = 1'b1;
        wait_req("R2");
        service(3, 1, 0, "R2");
        chk_eq("R2", "winner nest", nest_reg, 64'h8);
        irq_lines = '0;
        repeat (2) nxt();
        do_rti();
        repeat (3) nxt();

        // R2 NMI beats device 0
        nmi = 1'b1;
        irq_lines[0] = 1'b1;
        wait_req("R2");
        service(0, 1, 0, "R2");
        repeat (4) nxt();
        chk_eq("R3", "nmi not re-entered", int_req, 0);
        nmi = 1'b0;
        repeat (2) nxt();
        do_rti();
        wait_req("R2");
        service(1, 1, 1, "R2");
        irq_lines = '0;
        repeat (2) nxt();
        do_rti();
        repeat (3) nxt();

        // R9 software sources, lowest index first
        sw_raise = 2'b11;
        nxt();
        sw_raise = '0;
        chk_eq("R9", "latch pending sw", latch_reg, 64'h600);
        wait_req("R9");
        service(9, 1, 0, "R9");
        repeat (3) nxt();
        chk_eq("R9", "sw10 masked", int_req, 0);
        do_rti();
        chk_eq("R9", "latch after first sw", latch_reg, 64'h400);
        wait_req("R9");
        service(10, 1, 1, "R9");
        do_rti();
        chk_eq("R9", "latch clear", latch_reg, 0);
        repeat (3) nxt();

        // R4 gating
        int_en = 1'b0;
        irq_lines[0] = 1'b1;
        sw_raise[0] = 1'b1;
        nxt();
        sw_raise = '0;
        repeat (6) nxt();
        chk_eq("R4", "gated int_req", int_req, 0);
        chk_eq("R9", "gated sw still latched", latch_reg, 64'h200);
        nmi = 1'b1;
        wait_req("R4");
        service(0, 1, 0, "R4");
        nmi = 1'b0;
        repeat (2) nxt();
        do_rti();
        repeat (4) nxt();
        chk_eq("R4", "gated after nmi", int_req, 0);
        int_en = 1'b1;
        wait_req("R4");
        service(1, 1, 0, "R2");
        irq_lines = '0;
        repeat (2) nxt();
        do_rti();
        wait_req("R9");
        service(9, 1, 0, "R9");
        do_rti();
        chk_eq("R9", "latch clear again", latch_reg, 0);
        repeat (3) nxt();

        // R6 timeout
        irq_lines[4] = 1'b1;
        wait_req("R6");
        service(5, 0, 0, "R6");
        chk_eq("R6", "nest untouched", nest_reg, 0);
        chk_eq("R6", "latch untouched", latch_reg, 0);
        repeat (4) nxt();
        chk_eq("R6", "no retry", int_req, 0);

        // random single-device takes
        for (int it = 0; it < 40; it++) begin
            int  j   = int'($urandom % NI);
            bit  ext = 1'($urandom % 2);
            bit  vld = (($urandom % 4) != 0);
            irq_lines[j] = 1'b1;
            wait_req("R1");
            service(j + 1, vld, ext, "R7");
            if (vld) begin
                irq_lines = '0;
                repeat (2) nxt();
                do_rti();
                chk_eq("R8", "random nest clear", nest_reg, 0);
                chk_eq("R8", "random latch clear", latch_reg, 0);
            end else begin
                chk_eq("R6", "random no nest", nest_reg, 0);
            end
            repeat (3) nxt();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule